// File: doc/BRIEF.md
# Bus-Master Access Guard

This block checks each read or write on one bus master's command path against a set of programmable regions. Each region has a base address, a power-of-two size, an enable bit and separate read and write grants. The access is allowed when at least one enabled region contains the address and grants the requested direction. Any other access is blocked. On a blocked access, the address and direction are latched, and a one-cycle error pulse can be sent to a downstream error collector.

Software reaches the block through a small word-addressed register port. A selector register picks the region that the base, size and permission registers refer to. A 4-bit key register must hold 0xA before any other register takes a write. A second 4-bit key enables the error pulse. A read-only information register reports how many regions exist. With eight regions, a full-range read window, a peripheral write window and write-only windows at both ends of a RAM bank can all be held at once.

Top module: `acc_guard`

## Requirements
- R1: Register writes to offsets 1, 3, 4, 5 and 6 take effect only while the key register (offset 0, bits 3:0) holds 0xA. Writes to offset 0 are always accepted, and any value other than 0xA locks the block again.
- R2: `err_pulse` is high in the cycle after a blocked access only when the error key (offset 1, bits 3:0) held 0xA in the cycle of that access. A write to offset 1 in that same cycle affects only later accesses.
- R3: Offset 2 reads the implemented region count (8) and ignores writes.
- R4: Offset 3 selects the region that offsets 4, 5 and 6 access. A written value at or above the region count leaves the selection unchanged.
- R5: A region covers 2^E bytes starting at its base with the low E bits cleared. E is the size field (offset 5, bits 5:0) clamped to the range 5..32.
- R6: Permission bits at offset 6 are: bit 0 enable, bit 1 read grant, bit 2 write grant. The read grant and the write grant are independent of each other.
- R7: `acc_allow` is high when some enabled region contains `acc_addr` and grants the direction given by `acc_write`. `acc_block` equals `acc_valid` and not `acc_allow`. With no enabled region, every valid access is blocked.
- R8: After a blocked access, `err_addr` and `err_write` hold that access's address and direction from the next cycle until the next blocked access.
- R9: After reset the block is locked, the error key is 0, the selector is 0, and all region fields are 0. Register reads are combinational on `cfg_addr` and always permitted. Offset 7 reads 0.
- R10: Eight regions can hold at once a full-range read window, a peripheral write window, and write-only windows covering 0x0800_0000 to 0x0800_27FF and 0x0843_D800 to 0x0843_FFFF. Each 10 KB window is built from one 8 KB region and one 2 KB region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at `cfg_addr` |
| acc_valid | input | 1 | Master presents an access |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_allow | output | 1 | Address and direction permitted |
| acc_block | output | 1 | Valid access refused |
| err_pulse | output | 1 | One-cycle error event |
| err_addr | output | 32 | Address of the last refused access |
| err_write | output | 1 | Direction of the last refused access |

## Verification
A register write and a checked access can arrive in the same cycle. In that cycle, the access must be judged against the configuration from before the write. The bench provokes this in two ways. It writes the error key while a blocked access is presented. It also rewrites a region's permissions while an access hits that region. The behavioural reference model applies the write only after it has evaluated the access, so any design that lets the new value take effect early shows up as a miscompare on `acc_allow` or `err_pulse`.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;
  localparam logic [3:0] KEY_OPEN = 4'hA;
  localparam int SZ_W    = 6;
  localparam int MIN_EXP = 5;
  localparam int PB_EN   = 0;
  localparam int PB_RD   = 1;
  localparam int PB_WR   = 2;

  typedef enum logic [2:0] {
    OFS_KEY    = 3'd0,
    OFS_ERRKEY = 3'd1,
    OFS_INFO   = 3'd2,
    OFS_SEL    = 3'd3,
    OFS_BASE   = 3'd4,
    OFS_SIZE   = 3'd5,
    OFS_PERM   = 3'd6,
    OFS_RSVD   = 3'd7
  } cfg_ofs_e;
endpackage

// File: rtl/acc_guard_regs.sv
module acc_guard_regs
  import acc_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_REG  = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [2:0]                         cfg_addr,
  input  logic [ADDR_W-1:0]                  cfg_wdata,
  output logic [ADDR_W-1:0]                  cfg_rdata,
  output logic [N_REG-1:0][ADDR_W-1:0]       base_o,
  output logic [N_REG-1:0][SZ_W-1:0]         size_o,
  output logic [N_REG-1:0][2:0]              perm_o,
  output logic                               err_en_o
);
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;

  logic [3:0]       key_q, errkey_q;
  logic [IDX_W-1:0] sel_q;
  logic             unlocked;
  logic             wr_open;
  cfg_ofs_e         ofs;

  assign ofs      = cfg_ofs_e'(cfg_addr);
  assign unlocked = (key_q == KEY_OPEN);
  assign wr_open  = cfg_we && unlocked;
  assign err_en_o = (errkey_q == KEY_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q    <= '0;
      errkey_q <= '0;
      sel_q    <= '0;
    end else begin
      if (cfg_we && ofs == OFS_KEY) key_q <= cfg_wdata[3:0];
      if (wr_open && ofs == OFS_ERRKEY) errkey_q <= cfg_wdata[3:0];
      if (wr_open && ofs == OFS_SEL && cfg_wdata < ADDR_W'(N_REG))
        sel_q <= cfg_wdata[IDX_W-1:0];
    end
  end

  for (genvar i = 0; i < N_REG; i++) begin : g_slot
    logic hit_sel;
    assign hit_sel = wr_open && (sel_q == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[i] <= '0;
        size_o[i] <= '0;
        perm_o[i] <= '0;
      end else if (hit_sel) begin
        if (ofs == OFS_BASE) base_o[i] <= cfg_wdata;
        if (ofs == OFS_SIZE) size_o[i] <= cfg_wdata[SZ_W-1:0];
        if (ofs == OFS_PERM) perm_o[i] <= cfg_wdata[2:0];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (ofs)
      OFS_KEY:    cfg_rdata = ADDR_W'(key_q);
      OFS_ERRKEY: cfg_rdata = ADDR_W'(errkey_q);
      OFS_INFO:   cfg_rdata = ADDR_W'(N_REG);
      OFS_SEL:    cfg_rdata = ADDR_W'(sel_q);
      OFS_BASE:   cfg_rdata = base_o[sel_q];
      OFS_SIZE:   cfg_rdata = ADDR_W'(size_o[sel_q]);
      OFS_PERM:   cfg_rdata = ADDR_W'(perm_o[sel_q]);
      OFS_RSVD:   cfg_rdata = '0;
    endcase
  end

  // R1
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && cfg_we && ofs != OFS_KEY) |=>
      ($stable(base_o) && $stable(size_o) && $stable(perm_o) && $stable(err_en_o)));

  // R4
  sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && ofs == OFS_SEL && cfg_wdata >= ADDR_W'(N_REG)) |=> $stable(sel_q));
endmodule

// File: rtl/acc_guard_match.sv
module acc_guard_match
  import acc_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [SZ_W-1:0]   size,
  input  logic [2:0]        perm,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              hit,
  output logic              grant
);
  function automatic int eff_exp(input logic [SZ_W-1:0] s);
    int v;
    v = int'(s);
    if (v < MIN_EXP) v = MIN_EXP;
    if (v > ADDR_W)  v = ADDR_W;
    return v;
  endfunction

  function automatic logic [ADDR_W-1:0] span_mask(input int e);
    logic [ADDR_W:0] span;
    span = (ADDR_W+1)'(1) << e;
    return ~(span[ADDR_W-1:0] - {{(ADDR_W-1){1'b0}}, 1'b1});
  endfunction

  logic [ADDR_W-1:0] mask;
  logic              dir_ok;

  assign mask   = span_mask(eff_exp(size));
  assign hit    = perm[PB_EN] && ((addr & mask) == (base & mask));
  assign dir_ok = is_write ? perm[PB_WR] : perm[PB_RD];
  assign grant  = hit && dir_ok;

  // R6
  grant_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (hit && perm[PB_EN]));
endmodule

// File: rtl/acc_guard.sv
module acc_guard
  import acc_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_REG  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              acc_allow,
  output logic              acc_block,
  output logic              err_pulse,
  output logic [ADDR_W-1:0] err_addr,
  output logic              err_write
);
  logic [N_REG-1:0][ADDR_W-1:0] r_base;
  logic [N_REG-1:0][SZ_W-1:0]   r_size;
  logic [N_REG-1:0][2:0]        r_perm;
  logic                         err_en;
  logic [N_REG-1:0]             hit_vec, grant_vec, enabled_vec;
  logic                         blocked;

  acc_guard_regs #(.ADDR_W(ADDR_W), .N_REG(N_REG)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .base_o(r_base),
    .size_o(r_size), .perm_o(r_perm), .err_en_o(err_en)
  );

  for (genvar i = 0; i < N_REG; i++) begin : g_rgn
    acc_guard_match #(.ADDR_W(ADDR_W)) match_i (
      .clk(clk), .rst_n(rst_n), .base(r_base[i]), .size(r_size[i]),
      .perm(r_perm[i]), .addr(acc_addr), .is_write(acc_write),
      .hit(hit_vec[i]), .grant(grant_vec[i])
    );
    assign enabled_vec[i] = r_perm[i][PB_EN];
  end

  assign acc_allow = |grant_vec;
  assign blocked   = acc_valid && !acc_allow;
  assign acc_block = blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_addr  <= '0;
      err_write <= 1'b0;
    end else begin
      err_pulse <= blocked && err_en;
      if (blocked) begin
        err_addr  <= acc_addr;
        err_write <= acc_write;
      end
    end
  end

  // R7
  none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && enabled_vec == '0) |-> acc_block);

  // R7
  allow_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_allow |-> (hit_vec != '0));

  // R8
  err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_block |=> (err_addr == $past(acc_addr) && err_write == $past(acc_write)));

  // R2
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(acc_valid && !acc_allow));
endmodule

// File: tb/acc_guard_tb_top.sv
module acc_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = 32'd0;
  logic        acc_write = 1'b0;
  logic        acc_allow, acc_block, err_pulse, err_write;
  logic [31:0] err_addr;

  always #5 clk = ~clk;

  acc_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_allow(acc_allow),
    .acc_block(acc_block), .err_pulse(err_pulse), .err_addr(err_addr),
    .err_write(err_write)
  );

  // behavioural reference state
  longint unsigned m_base [8];
  int              m_size [8];
  int              m_perm [8];
  int   m_key, m_errkey, m_sel;
  bit   m_pulse, m_ewr;
  longint unsigned m_eaddr;
  int   vectors = 0, fails = 0;
  string tag = "R9";
  bit   finished = 0;

  function automatic bit m_allow(longint unsigned a, bit w);
    bit ok = 0;
    for (int i = 0; i < 8; i++) begin
      int e = m_size[i];
      longint unsigned lo, hi;
      if (e < 5) e = 5;
      if (e > 32) e = 32;
      lo = (m_base[i] / (64'd1 << e)) * (64'd1 << e);
      hi = lo + (64'd1 << e);
      if ((m_perm[i] % 2) == 1 && a >= lo && a < hi &&
          (w ? ((m_perm[i] / 4) % 2 == 1) : ((m_perm[i] / 2) % 2 == 1)))
        ok = 1;
    end
    return ok;
  endfunction

  function automatic longint unsigned m_rdata(int ra);
    case (ra)
      0: return m_key;
      1: return m_errkey;
      2: return 8;
      3: return m_sel;
      4: return m_base[m_sel];
      5: return m_size[m_sel];
      6: return m_perm[m_sel];
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string what, longint unsigned act, longint unsigned exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit we, int ra, longint unsigned wd, bit v, longint unsigned a, bit w);
    bit al, blk;
    cfg_we = we; cfg_addr = 3'(ra); cfg_wdata = 32'(wd);
    acc_valid = v; acc_addr = 32'(a); acc_write = w;
    #1;
    vectors++;
    al  = m_allow(a, w);
    blk = v && !al;
    cmp("cfg_rdata", cfg_rdata, m_rdata(ra));
    cmp("acc_allow", acc_allow, al);
    cmp("acc_block", acc_block, blk);
    cmp("err_pulse", err_pulse, m_pulse);
    cmp("err_addr",  err_addr,  m_eaddr);
    cmp("err_write", err_write, m_ewr);
    // model clock edge: access judged on the old state, then the write lands
    m_pulse = blk && (m_errkey == 10);
    if (blk) begin m_eaddr = a; m_ewr = w; end
    if (we) begin
      if (ra == 0) m_key = int'(wd % 16);
      else if (m_key == 10) begin
        case (ra)
          1: m_errkey = int'(wd % 16);
          3: if (wd < 8) m_sel = int'(wd);
          4: m_base[m_sel] = wd;
          5: m_size[m_sel] = int'(wd % 64);
          6: m_perm[m_sel] = int'(wd % 8);
          default: ;
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(int ra, longint unsigned wd); step(1, ra, wd, 0, 0, 0); endtask
  task automatic rd(int ra); step(0, ra, 0, 0, 0, 0); endtask
  task automatic acc(longint unsigned a, bit w); step(0, 0, 0, 1, a, w); endtask

  task automatic prog(int idx, longint unsigned b, int sz, int pm);
    wr(3, idx); wr(4, b); wr(5, sz); wr(6, pm);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_size[i] = 0; m_perm[i] = 0; end
    m_key = 0; m_errkey = 0; m_sel = 0; m_pulse = 0; m_ewr = 0; m_eaddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state on every offset
    tag = "R9";
    for (int r = 0; r < 8; r++) rd(r);

    // R1: writes while locked are ignored
    tag = "R1";
    wr(6, 7); wr(4, 32'h1234_0000); wr(1, 10); wr(3, 2);
    for (int r = 0; r < 8; r++) rd(r);

    // R7: nothing enabled blocks everything; R2 pulse disabled; R8 latch
    tag = "R7";
    acc(32'h0000_0040, 0); acc(32'hFFFF_FFFC, 1);
    tag = "R8";
    rd(0); rd(0);

    // R1: unlock, R2: enable the pulse
    tag = "R1";
    wr(0, 10); rd(0);
    tag = "R2";
    wr(1, 10);
    acc(32'h0000_1000, 1); rd(0);
    // R2: same-cycle error-key write and blocked access
    step(1, 1, 3, 1, 32'h0000_2000, 0);
    acc(32'h0000_3000, 1); rd(1);
    wr(1, 10);

    // R3: info register read-only
    tag = "R3";
    rd(2); wr(2, 3); rd(2);

    // R4: out-of-range selector ignored
    tag = "R4";
    wr(3, 5); wr(3, 8); rd(3); wr(3, 32'hFFFF_FFFF); rd(3); wr(3, 7); rd(3);

    // R5: misaligned base masked, size clamping
    tag = "R5";
    prog(0, 32'h1234_5678, 12, 7);
    acc(32'h1234_5000, 0); acc(32'h1234_4FFF, 0);
    acc(32'h1234_5FFF, 1); acc(32'h1234_6000, 1);
    prog(1, 32'h0000_0100, 0, 3);
    acc(32'h0000_011F, 0); acc(32'h0000_0120, 0);
    prog(0, 32'h0, 40, 0);
    prog(2, 32'h5555_5555, 40, 3);
    acc(32'hDEAD_BEE0, 0); acc(32'h0000_0000, 0);

    // R6: write-only region; same-cycle permission rewrite
    tag = "R6";
    prog(2, 32'h4000_0000, 16, 5);
    acc(32'h4000_0010, 1); acc(32'h4000_0010, 0);
    wr(3, 2);
    step(1, 6, 3, 1, 32'h4000_0020, 1);
    acc(32'h4000_0020, 1); acc(32'h4000_0020, 0);
    rd(6);

    // R10: composite layout
    tag = "R10";
    for (int i = 0; i < 8; i++) prog(i, 0, 0, 0);
    prog(0, 32'h0, 32, 3);
    prog(1, 32'hF000_0000, 28, 5);
    prog(2, 32'h0800_0000, 13, 5);
    prog(3, 32'h0800_2000, 11, 5);
    prog(4, 32'h0843_E000, 13, 5);
    prog(5, 32'h0843_D800, 11, 5);
    acc(32'h0800_0000, 1); acc(32'h0800_27FF, 1); acc(32'h0800_2800, 1);
    acc(32'h0843_D7FF, 1); acc(32'h0843_D800, 1); acc(32'h0843_FFFF, 1);
    acc(32'h0844_0000, 1); acc(32'hF012_3450, 1); acc(32'hEFFF_FFFC, 1);
    acc(32'h0820_0000, 0); acc(32'h0820_0000, 1);
    for (int k = 0; k < 200; k++) acc({$urandom} & 32'hFFFF_FFFF, k[0]);

    // R1: relock with another value, writes ignored again
    tag = "R1";
    wr(0, 5); rd(0);
    wr(3, 0); wr(6, 0); wr(1, 0);
    rd(3); rd(6); rd(1);
    acc(32'h0800_0100, 1); acc(32'h0900_0000, 1);
    tag = "R8";
    rd(0); rd(0);

    summary();
  end
endmodule